// File: doc/BRIEF.md
# HDLC Frame Receiver with Address Filter

This block takes a serial bit stream, one bit per `bit_en` strobe, and turns it into a stream of frame data bytes. It first looks for a flag pattern to find where a frame starts and where it ends. It removes the zeros the sender added after runs of ones, and it recognises an abort sequence. It also checks the 16-bit cyclic check field that ends every frame.

Filtering uses the first one or two bytes of each frame. A frame that fails the filter produces no output at all. A frame that passes is delivered without its two check bytes. A start marker goes out with the first byte. An end marker goes out together with a two-bit status code when the frame closes. An aborted frame also raises a one-cycle abort pulse.

The block sits after a line clock-recovery stage and feeds a byte buffer. The configuration inputs are expected to stay stable while a frame is being received.

Top module: `hdlc_rx_top`

## Requirements
- R1: While `rst_n` is low at a clock edge, `out_valid`, `stat_valid` and `abort_pulse` are low after that edge.
- R2: Only data between flags is delivered, and flags never appear on the output. Each group of 8 data bits forms one byte, and the first bit received becomes bit 7 of `out_data`. Byte and status events appear two clock cycles after the `bit_en` cycle that completes them.
- R3: Inside a frame, a 0 that directly follows five consecutive 1s is removed before bytes are assembled.
- R4: An abort is seven consecutive 1s inside a frame that has received at least one data bit. It ends the frame with `stat_code` = 2'b10 and a one-cycle `abort_pulse`. The receiver resynchronises on the next flag.
- R5: The check register starts at all ones and uses x^16+x^12+x^5+1, shifting the most significant bit first. It runs over the data bits and the check bits together. A residue of 16'h1D0F gives `stat_code` 2'b00; any other residue gives 2'b01.
- R6: If a frame has fewer than 2 data bytes before its 2 check bytes, it ends with `stat_code` 2'b11. A frame whose bit count is not a multiple of 8 also ends with 2'b11.
- R7: When `addr_mode` = 2'b01, a frame is accepted only if its first byte equals `addr_a`.
- R8: When `addr_mode` = 2'b10, a frame is accepted only if its first byte equals `addr_a` and its second byte equals `addr_b`. When `addr_mode` = 2'b00, every frame is accepted.
- R9: When `allcall_en` is 1, a frame whose first byte is 8'hFF is accepted in any mode.
- R10: A frame that fails the address filter produces no byte, no end marker, no status and no abort pulse.
- R11: `out_sof` is high with the first delivered byte of a frame. `out_eof` is high together with `stat_valid` at the end of a frame that delivered bytes. For status 2'b00 and 2'b01, the last data byte comes with `out_eof`, and the two check bytes are never delivered.
- R12: Back-to-back flags with no data between them, and runs of idle 1s outside a frame, produce no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bit_en | input | 1 | Marks the cycle in which `rx_bit` is valid |
| rx_bit | input | 1 | Serial line bit |
| addr_mode | input | 2 | 00 accept all, 01 one-byte match, 10 two-byte match, 11 all-call only |
| addr_a | input | 8 | Expected first address byte |
| addr_b | input | 8 | Expected second address byte |
| allcall_en | input | 1 | Accept frames whose first byte is 8'hFF |
| out_valid | output | 1 | A data byte is on `out_data` |
| out_data | output | 8 | Delivered data byte |
| out_sof | output | 1 | First byte of a frame |
| out_eof | output | 1 | End of a delivered frame |
| stat_valid | output | 1 | Frame status is on `stat_code` |
| stat_code | output | 2 | 00 good, 01 check error, 10 abort, 11 short or not whole bytes |
| abort_pulse | output | 1 | One-cycle abort event |

## Verification
The assertions assume three things about the inputs. First, `bit_en` is never high in two consecutive cycles. Second, a new frame event cannot arrive before the previous one has been handled. Third, the address configuration does not change while a frame is in progress. The stimulus holds `bit_en` high for one cycle and then low for at least one cycle. It changes `addr_mode`, `addr_a`, `addr_b` and `allcall_en` only while the line carries idle flags. Each frame is built with correct zero stuffing, and the check field is computed by the bench from the polynomial and sent as its complement. Corrupted check fields, cut-short frames and raw runs of ones are then injected on purpose.

// File: rtl/hdlc_rx_pkg.sv
// Shared constants for the HDLC receiver: byte width, check polynomial,
// status codes and address filter modes.
package hdlc_rx_pkg;
    localparam int          BYTE_W     = 8;
    localparam int          CHK_W      = 16;
    localparam int          CHK_BYTES  = CHK_W / BYTE_W;
    localparam int          MIN_DATA   = 2;
    localparam logic [15:0] CHK_POLY   = 16'h1021;
    localparam logic [15:0] CHK_INIT   = 16'hFFFF;
    localparam logic [15:0] CHK_RESID  = 16'h1D0F;

    localparam logic [1:0]  ST_GOOD    = 2'b00;
    localparam logic [1:0]  ST_BADCHK  = 2'b01;
    localparam logic [1:0]  ST_ABORT   = 2'b10;
    localparam logic [1:0]  ST_SHORT   = 2'b11;

    localparam logic [1:0]  AM_ANY     = 2'b00;
    localparam logic [1:0]  AM_ONE     = 2'b01;
    localparam logic [1:0]  AM_TWO     = 2'b10;
    localparam logic [1:0]  AM_CALL    = 2'b11;
endpackage

// File: rtl/hdlc_rx_deframe.sv
// Line deframer. It counts runs of ones to find flags, aborts and stuffed
// zeros. Candidate data bits go through a delay line one bit shorter than a
// flag, so the first part of a flag is dropped once the flag is recognised.
// Assumes: bit_en is a single-cycle strobe.
module hdlc_rx_deframe #(
    parameter int FLAG_RUN = 6
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bit_en,
    input  logic rx_bit,
    output logic dbit_valid,
    output logic dbit,
    output logic flag_evt,
    output logic abort_evt
);
    localparam int STUFF_RUN = FLAG_RUN - 1;
    localparam int DL_D      = FLAG_RUN + 1;
    localparam int RUN_MAX   = FLAG_RUN + 1;
    localparam int RUN_W     = $clog2(RUN_MAX + 1);
    localparam int CNT_W     = $clog2(DL_D + 1);

    logic [RUN_W-1:0] ones;
    logic [DL_D-1:0]  dline;
    logic [CNT_W-1:0] dcnt;
    logic             in_frame;
    logic             is_flag, is_abort, is_stuff, is_cand;

    // Classify the incoming bit by the length of the run of ones before it.
    always_comb begin
        is_flag  = bit_en && !rx_bit && (ones == RUN_W'(FLAG_RUN));
        is_abort = bit_en &&  rx_bit && (ones == RUN_W'(FLAG_RUN));
        is_stuff = bit_en && !rx_bit && (ones == RUN_W'(STUFF_RUN));
        is_cand  = bit_en && !is_flag && !is_stuff &&
                   !(rx_bit && (ones >= RUN_W'(FLAG_RUN)));
    end

    // Track the run of ones, the frame state and the delay line.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ones       <= '0;
            dline      <= '0;
            dcnt       <= '0;
            in_frame   <= 1'b0;
            dbit_valid <= 1'b0;
            dbit       <= 1'b0;
            flag_evt   <= 1'b0;
            abort_evt  <= 1'b0;
        end else begin
            dbit_valid <= 1'b0;
            flag_evt   <= 1'b0;
            abort_evt  <= 1'b0;
            if (bit_en) begin
                if (!rx_bit)
                    ones <= '0;
                else if (ones != RUN_W'(RUN_MAX))
                    ones <= ones + 1'b1;
            end
            if (is_flag) begin
                dline    <= '0;
                dcnt     <= '0;
                in_frame <= 1'b1;
                flag_evt <= 1'b1;
            end else if (is_abort) begin
                dline     <= '0;
                dcnt      <= '0;
                abort_evt <= in_frame;
                in_frame  <= 1'b0;
            end else if (is_cand) begin
                dline <= {dline[DL_D-2:0], rx_bit};
                if (dcnt == CNT_W'(DL_D)) begin
                    dbit_valid <= in_frame;
                    dbit       <= dline[DL_D-1];
                end else begin
                    dcnt <= dcnt + 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/hdlc_rx_chk_reg.sv
// Bit-serial check register, most significant bit first. It is cleared to
// its start value at each frame boundary.
// Assumes: clr and en are never high in the same cycle.
module hdlc_rx_chk_reg #(
    parameter int          W    = 16,
    parameter logic [15:0] POLY = 16'h1021,
    parameter logic [15:0] INIT = 16'hFFFF
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         en,
    input  logic         din,
    output logic [W-1:0] chk
);
    logic fb;

    // Feedback is the outgoing top bit combined with the new data bit.
    always_comb fb = chk[W-1] ^ din;

    // Preset on reset or frame boundary; otherwise shift one data bit.
    always_ff @(posedge clk) begin
        if (!rst_n || clr)
            chk <= INIT[W-1:0];
        else if (en)
            chk <= {chk[W-2:0], 1'b0} ^ (fb ? POLY[W-1:0] : '0);
    end
endmodule

// File: rtl/hdlc_rx_frame.sv
// Byte assembly, check-byte holdback, address filter and frame status.
// Bytes wait in a holdback line one byte longer than the check field. The
// oldest byte is released only when a newer byte arrives. The filter decision
// is made when the first byte is released, when the second byte is known.
// Assumes: dbit_valid never coincides with flag_evt or abort_evt.
module hdlc_rx_frame
    import hdlc_rx_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              dbit_valid,
    input  logic              dbit,
    input  logic              flag_evt,
    input  logic              abort_evt,
    input  logic              chk_ok,
    input  logic [1:0]        addr_mode,
    input  logic [BYTE_W-1:0] addr_a,
    input  logic [BYTE_W-1:0] addr_b,
    input  logic              allcall_en,
    output logic              out_valid,
    output logic [BYTE_W-1:0] out_data,
    output logic              out_sof,
    output logic              out_eof,
    output logic              stat_valid,
    output logic [1:0]        stat_code,
    output logic              abort_pulse
);
    localparam int HOLD      = CHK_BYTES + 1;
    localparam int MIN_TOTAL = MIN_DATA + CHK_BYTES;
    localparam int BIT_W     = $clog2(BYTE_W);
    localparam int NB_W      = $clog2(MIN_TOTAL + 1);
    localparam int HC_W      = $clog2(HOLD + 1);

    logic [BYTE_W-1:0] shreg;
    logic [BIT_W-1:0]  bitcnt;
    logic              got_bit;
    logic [NB_W-1:0]   nbytes;
    logic [BYTE_W-1:0] hold [HOLD];
    logic [HC_W-1:0]   hcnt;
    logic              dec_done, dec_acc, sof_done;
    logic [BYTE_W-1:0] new_byte;
    logic              byte_done, addr_ok, end_evt, report;
    logic [1:0]        end_code;

    // Next byte value and byte-complete strobe.
    always_comb begin
        new_byte  = {shreg[BYTE_W-2:0], dbit};
        byte_done = dbit_valid && (bitcnt == BIT_W'(BYTE_W - 1));
    end

    // Address decision using the two oldest held bytes (first and second byte).
    always_comb begin
        case (addr_mode)
            AM_ANY:  addr_ok = 1'b1;
            AM_ONE:  addr_ok = (hold[HOLD-1] == addr_a);
            AM_TWO:  addr_ok = (hold[HOLD-1] == addr_a) && (hold[HOLD-2] == addr_b);
            default: addr_ok = 1'b0;
        endcase
        if (allcall_en && (hold[HOLD-1] == '1))
            addr_ok = 1'b1;
    end

    // Status of a closing frame, in priority order.
    always_comb begin
        if (abort_evt)
            end_code = ST_ABORT;
        else if ((bitcnt != '0) || (nbytes < NB_W'(MIN_TOTAL)))
            end_code = ST_SHORT;
        else if (chk_ok)
            end_code = ST_GOOD;
        else
            end_code = ST_BADCHK;
        end_evt = (flag_evt || abort_evt) && got_bit;
        report  = end_evt && !(dec_done && !dec_acc);
    end

    // Frame state, holdback line and output events.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shreg       <= '0;
            bitcnt      <= '0;
            got_bit     <= 1'b0;
            nbytes      <= '0;
            hcnt        <= '0;
            dec_done    <= 1'b0;
            dec_acc     <= 1'b0;
            sof_done    <= 1'b0;
            out_valid   <= 1'b0;
            out_data    <= '0;
            out_sof     <= 1'b0;
            out_eof     <= 1'b0;
            stat_valid  <= 1'b0;
            stat_code   <= ST_GOOD;
            abort_pulse <= 1'b0;
            for (int i = 0; i < HOLD; i++) hold[i] <= '0;
        end else begin
            out_valid   <= 1'b0;
            out_sof     <= 1'b0;
            out_eof     <= 1'b0;
            stat_valid  <= 1'b0;
            abort_pulse <= 1'b0;
            if (flag_evt || abort_evt) begin
                if (report) begin
                    stat_valid  <= 1'b1;
                    stat_code   <= end_code;
                    abort_pulse <= abort_evt;
                    out_eof     <= dec_done;
                    if (dec_done && !end_code[1]) begin
                        out_valid <= 1'b1;
                        out_data  <= hold[HOLD-1];
                        out_sof   <= !sof_done;
                    end
                end
                bitcnt   <= '0;
                got_bit  <= 1'b0;
                nbytes   <= '0;
                hcnt     <= '0;
                dec_done <= 1'b0;
                dec_acc  <= 1'b0;
                sof_done <= 1'b0;
            end else if (dbit_valid) begin
                shreg   <= new_byte;
                bitcnt  <= bitcnt + 1'b1;
                got_bit <= 1'b1;
                if (byte_done) begin
                    if (nbytes != NB_W'(MIN_TOTAL))
                        nbytes <= nbytes + 1'b1;
                    hold[0] <= new_byte;
                    for (int i = 1; i < HOLD; i++) hold[i] <= hold[i-1];
                    if (hcnt == HC_W'(HOLD)) begin
                        dec_done <= 1'b1;
                        dec_acc  <= dec_done ? dec_acc : addr_ok;
                        if (dec_done ? dec_acc : addr_ok) begin
                            out_valid <= 1'b1;
                            out_data  <= hold[HOLD-1];
                            out_sof   <= !sof_done;
                            sof_done  <= 1'b1;
                        end
                    end else begin
                        hcnt <= hcnt + 1'b1;
                    end
                end
            end
        end
    end
endmodule

// File: rtl/hdlc_rx_top.sv
// HDLC frame receiver top level: deframer, check register and frame/byte stage.
// Assumes: bit_en is never high in two consecutive cycles, and the address
// configuration changes only between frames.
module hdlc_rx_top
    import hdlc_rx_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       bit_en,
    input  logic       rx_bit,
    input  logic [1:0] addr_mode,
    input  logic [7:0] addr_a,
    input  logic [7:0] addr_b,
    input  logic       allcall_en,
    output logic       out_valid,
    output logic [7:0] out_data,
    output logic       out_sof,
    output logic       out_eof,
    output logic       stat_valid,
    output logic [1:0] stat_code,
    output logic       abort_pulse
);
    logic             dbit_valid, dbit, flag_evt, abort_evt, chk_ok;
    logic [CHK_W-1:0] chk;

    // A residue equal to the fixed constant marks an intact frame.
    always_comb chk_ok = (chk == CHK_RESID[CHK_W-1:0]);

    hdlc_rx_deframe #(.FLAG_RUN(6)) u_deframe (
        .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .rx_bit(rx_bit),
        .dbit_valid(dbit_valid), .dbit(dbit),
        .flag_evt(flag_evt), .abort_evt(abort_evt)
    );

    hdlc_rx_chk_reg #(.W(CHK_W), .POLY(CHK_POLY), .INIT(CHK_INIT)) u_chk_reg (
        .clk(clk), .rst_n(rst_n), .clr(flag_evt || abort_evt),
        .en(dbit_valid), .din(dbit), .chk(chk)
    );

    hdlc_rx_frame u_frame (
        .clk(clk), .rst_n(rst_n), .dbit_valid(dbit_valid), .dbit(dbit),
        .flag_evt(flag_evt), .abort_evt(abort_evt), .chk_ok(chk_ok),
        .addr_mode(addr_mode), .addr_a(addr_a), .addr_b(addr_b),
        .allcall_en(allcall_en),
        .out_valid(out_valid), .out_data(out_data), .out_sof(out_sof),
        .out_eof(out_eof), .stat_valid(stat_valid), .stat_code(stat_code),
        .abort_pulse(abort_pulse)
    );
endmodule

// File: rtl/hdlc_rx_checker.sv
// Port-level properties of the HDLC receiver, attached by bind.
module hdlc_rx_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       bit_en,
    input logic       out_valid,
    input logic       out_sof,
    input logic       out_eof,
    input logic       stat_valid,
    input logic [1:0] stat_code,
    input logic       abort_pulse
);
    // R1: a reset cycle leaves every event output low.
    p_reset_quiet_r1: assert property (@(posedge clk)
        !rst_n |=> (!out_valid && !stat_valid && !abort_pulse));

    // R2: byte and status events follow a bit strobe two cycles earlier.
    p_paced_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid || stat_valid) |-> $past(bit_en, 2));

    // R4: the abort pulse comes with the abort status code.
    p_abort_code_r4: assert property (@(posedge clk) disable iff (!rst_n)
        abort_pulse |-> (stat_valid && stat_code == 2'b10));

    // R4: an abort status is always accompanied by the pulse.
    p_abort_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_valid && stat_code == 2'b10) |-> abort_pulse);

    // R5: a checked-length frame closes with its last byte and end marker.
    p_last_byte_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_valid && !stat_code[1]) |-> (out_valid && out_eof));

    // R6: a short or ragged frame delivers no byte at its end.
    p_short_nobyte_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_valid && stat_code == 2'b11) |-> !out_valid);

    // R11: markers accompany their events.
    p_eof_status_r11: assert property (@(posedge clk) disable iff (!rst_n)
        out_eof |-> stat_valid);
    p_sof_byte_r11: assert property (@(posedge clk) disable iff (!rst_n)
        out_sof |-> out_valid);
endmodule

bind hdlc_rx_top hdlc_rx_checker u_checker (
    .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .out_valid(out_valid),
    .out_sof(out_sof), .out_eof(out_eof), .stat_valid(stat_valid),
    .stat_code(stat_code), .abort_pulse(abort_pulse)
);

// File: tb/tb_hdlc_rx_top.sv
// Directed bench: one task per scenario, each checking its own results.
module tb_hdlc_rx_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bit_en = 1'b0;
    logic       rx_bit = 1'b1;
    logic [1:0] addr_mode = 2'b00;
    logic [7:0] addr_a = 8'h00;
    logic [7:0] addr_b = 8'h00;
    logic       allcall_en = 1'b0;
    logic       out_valid, out_sof, out_eof, stat_valid, abort_pulse;
    logic [7:0] out_data;
    logic [1:0] stat_code;

    int checks = 0;
    int errors = 0;
    int st_ones = 0;
    logic [7:0] fr [0:15];
    int cap_n = 0, st_n = 0, ab_n = 0, eof_n = 0;
    logic [7:0] cap_d [0:63];
    logic       cap_sof [0:63];
    logic       cap_eof [0:63];
    logic [1:0] last_code = 2'b00;

    always #2 clk = ~clk;

    hdlc_rx_top dut (
        .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .rx_bit(rx_bit),
        .addr_mode(addr_mode), .addr_a(addr_a), .addr_b(addr_b),
        .allcall_en(allcall_en), .out_valid(out_valid), .out_data(out_data),
        .out_sof(out_sof), .out_eof(out_eof), .stat_valid(stat_valid),
        .stat_code(stat_code), .abort_pulse(abort_pulse)
    );

    // Record output events away from the active edge.
    always @(negedge clk) begin
        if (rst_n) begin
            if (out_valid && cap_n < 64) begin
                cap_d[cap_n]   = out_data;
                cap_sof[cap_n] = out_sof;
                cap_eof[cap_n] = out_eof;
                cap_n++;
            end
            if (stat_valid) begin
                st_n++;
                last_code = stat_code;
            end
            if (abort_pulse) ab_n++;
            if (out_eof) eof_n++;
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic clr_cap();
        cap_n = 0; st_n = 0; ab_n = 0; eof_n = 0;
    endtask

    task automatic tx_raw(input logic b);
        @(negedge clk);
        bit_en = 1'b1;
        rx_bit = b;
        @(negedge clk);
        bit_en = 1'b0;
    endtask

    task automatic tx_flag();
        tx_raw(1'b0);
        for (int i = 0; i < 6; i++) tx_raw(1'b1);
        tx_raw(1'b0);
        st_ones = 0;
    endtask

    task automatic tx_dbit(input logic b);
        tx_raw(b);
        if (b) begin
            st_ones++;
            if (st_ones == 5) begin
                tx_raw(1'b0);
                st_ones = 0;
            end
        end else begin
            st_ones = 0;
        end
    endtask

    task automatic tx_byte(input logic [7:0] v);
        for (int i = 7; i >= 0; i--) tx_dbit(v[i]);
    endtask

    function automatic logic [15:0] calc_chk(input int n);
        logic [15:0] c = 16'hFFFF;
        for (int k = 0; k < n; k++)
            for (int i = 7; i >= 0; i--) begin
                logic f = c[15] ^ fr[k][i];
                c = {c[14:0], 1'b0};
                if (f) c = c ^ 16'h1021;
            end
        return c;
    endfunction

    // Send the opening flag, n data bytes and the check field (optionally
    // corrupted), without the closing flag.
    task automatic tx_body(input int n, input bit bad);
        logic [15:0] f = ~calc_chk(n);
        if (bad) f[0] = ~f[0];
        tx_flag();
        for (int k = 0; k < n; k++) tx_byte(fr[k]);
        tx_byte(f[15:8]);
        tx_byte(f[7:0]);
    endtask

    task automatic tx_frame(input int n, input bit bad);
        tx_body(n, bad);
        tx_flag();
        tx_flag();
        repeat (6) @(negedge clk);
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk("R1 out_valid after reset", int'(out_valid), 0);
        chk("R1 stat_valid after reset", int'(stat_valid), 0);
        chk("R1 abort_pulse after reset", int'(abort_pulse), 0);
    endtask

    task automatic t_good();
        addr_mode = 2'b00; allcall_en = 1'b0;
        fr[0] = 8'hA5; fr[1] = 8'hFF; fr[2] = 8'h7E; fr[3] = 8'h3E; fr[4] = 8'h01;
        clr_cap();
        tx_frame(5, 1'b0);
        chk("R2 byte count without check bytes", cap_n, 5);
        for (int k = 0; k < 5; k++)
            chk("R3 R2 destuffed byte value", int'(cap_d[k]), int'(fr[k]));
        chk("R11 sof on first byte", int'(cap_sof[0]), 1);
        chk("R11 no sof on second byte", int'(cap_sof[1]), 0);
        chk("R11 eof on last byte", int'(cap_eof[4]), 1);
        chk("R5 one status", st_n, 1);
        chk("R5 good status code", int'(last_code), 0);
    endtask

    task automatic t_badchk();
        fr[0] = 8'h11; fr[1] = 8'h22; fr[2] = 8'h33;
        clr_cap();
        tx_frame(3, 1'b1);
        chk("R5 bytes delivered on check error", cap_n, 3);
        chk("R5 check error code", int'(last_code), 1);
        chk("R11 eof count on check error", eof_n, 1);
    endtask

    task automatic t_single();
        addr_mode = 2'b01; addr_a = 8'h31; allcall_en = 1'b0;
        fr[0] = 8'h31; fr[1] = 8'h90; fr[2] = 8'h5A;
        clr_cap();
        tx_frame(3, 1'b0);
        chk("R7 matching single address delivered", cap_n, 3);
        chk("R7 matching status", int'(last_code), 0);
        fr[0] = 8'h32;
        clr_cap();
        tx_frame(3, 1'b0);
        chk("R7 R10 mismatching single address bytes", cap_n, 0);
        chk("R10 mismatching single address status", st_n, 0);
        chk("R10 mismatching single address eof", eof_n, 0);
    endtask

    task automatic t_dual();
        addr_mode = 2'b10; addr_a = 8'h31; addr_b = 8'hC4;
        fr[0] = 8'h31; fr[1] = 8'hC4; fr[2] = 8'h77;
        clr_cap();
        tx_frame(3, 1'b0);
        chk("R8 matching dual address delivered", cap_n, 3);
        fr[1] = 8'hC5;
        clr_cap();
        tx_frame(3, 1'b0);
        chk("R8 R10 mismatching second byte bytes", cap_n, 0);
        chk("R10 mismatching second byte status", st_n, 0);
    endtask

    task automatic t_allcall();
        addr_mode = 2'b01; addr_a = 8'h31; allcall_en = 1'b1;
        fr[0] = 8'hFF; fr[1] = 8'h12; fr[2] = 8'h34;
        clr_cap();
        tx_frame(3, 1'b0);
        chk("R9 all-call accepted", cap_n, 3);
        chk("R9 all-call status", st_n, 1);
        allcall_en = 1'b0;
        clr_cap();
        tx_frame(3, 1'b0);
        chk("R9 all-call rejected when disabled", cap_n, 0);
        addr_mode = 2'b00;
    endtask

    task automatic t_short();
        fr[0] = 8'h42;
        clr_cap();
        tx_frame(1, 1'b0);
        chk("R6 short frame status", int'(last_code), 3);
        chk("R6 short frame status count", st_n, 1);
        chk("R6 short frame no bytes", cap_n, 0);
        fr[0] = 8'h10; fr[1] = 8'h20; fr[2] = 8'h30;
        clr_cap();
        tx_body(3, 1'b0);
        tx_dbit(1'b1); tx_dbit(1'b0); tx_dbit(1'b1);
        tx_flag();
        tx_flag();
        repeat (6) @(negedge clk);
        chk("R6 ragged frame status", int'(last_code), 3);
        chk("R6 ragged frame eof count", eof_n, 1);
        chk("R6 ragged frame last byte not end", int'(cap_eof[cap_n-1]), 0);
    endtask

    task automatic t_abort();
        for (int k = 0; k < 6; k++) fr[k] = 8'h0F + 8'(k);
        clr_cap();
        tx_flag();
        for (int k = 0; k < 6; k++) tx_byte(fr[k]);
        for (int i = 0; i < 8; i++) tx_raw(1'b1);
        tx_flag();
        repeat (6) @(negedge clk);
        chk("R4 abort status", int'(last_code), 2);
        chk("R4 abort pulse count", ab_n, 1);
        chk("R4 abort eof count", eof_n, 1);
        fr[0] = 8'h5C; fr[1] = 8'hC5; fr[2] = 8'h99;
        clr_cap();
        tx_frame(3, 1'b0);
        chk("R4 resync after abort bytes", cap_n, 3);
        chk("R4 resync after abort status", int'(last_code), 0);
    endtask

    task automatic t_idle();
        clr_cap();
        for (int i = 0; i < 5; i++) tx_flag();
        for (int i = 0; i < 20; i++) tx_raw(1'b1);
        tx_flag();
        tx_flag();
        repeat (6) @(negedge clk);
        chk("R12 idle bytes", cap_n, 0);
        chk("R12 idle status", st_n, 0);
        chk("R12 idle abort", ab_n, 0);
    endtask

    task automatic finish_run();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        for (int i = 0; i < 3; i++) tx_raw(1'b1);
        tx_flag();
        t_good();
        t_badchk();
        t_single();
        t_dual();
        t_allcall();
        t_short();
        t_abort();
        t_idle();
        finish_run();
    end
endmodule